// File: doc/BRIEF.md
# Two-Stage Configurable Shuffle Network

This block sits between a square array of K×K processing elements and K check units. Each cycle it takes one K×K block of 6-bit words, one word per processing element. It permutes the block in two stages and delivers it so that every check unit receives one row of K words. The first stage shuffles each row on its own. The second stage shuffles each column on its own. Every row shuffler and every column shuffler has a fixed permutation of its own, and a single control bit per cycle chooses between that permutation and a straight pass-through. Because the control words change on every cycle, the overall connectivity looks random even though only two small shuffler arrays are involved.

The results from the check units, 5 bits per word, travel back over a separate set of wires. The return route is the exact inverse of the forward route, so each result arrives at the processing element whose word produced it. To make this work, the return path uses the control words from three cycles earlier. Those three cycles match the delay of the external loop: one output register here, one pipeline stage in the check unit, and one input register here. The control words come from two built-in tables of L entries. A table index advances by one on every clock and wraps after L−1. A start pulse restarts it at entry 0 at the beginning of each check-processing phase.

Both data paths are streams marked with a valid flag and have no ready. The loop runs in lock-step with a fixed schedule, so back-pressure is not possible. A beat is taken whenever its valid input is high, and a sender must never stall. K is a power of two and both permutation multipliers must be odd.

Top module: `shuffle_net`

## Requirements
- R1: During reset and in the first cycle after it, fwd_vld_o and bwd_vld_o are 0 and fwd_data_o and bwd_data_o are all zero; the table index restarts at 0.
- R2: The table entry e used by the forward beat sampled at a clock edge is 0 if start_i is high at that edge, and otherwise the previous edge's entry plus 1, wrapping from L−1 to 0; it advances on every edge whether or not a beat is present.
- R3: Entry e holds row word rotl(ROW_SEED, e mod K) XOR (e mod 2^K) and column word rotl(COL_SEED, (e+1) mod K) XOR (3e mod 2^K); bit b of rotl(v,s) is bit (b−s) mod K of v.
- R4: Row stage: for row x, output lane j takes input lane (j·ROW_MUL + ROW_OFS + x) mod K when row-word bit x is 1, and lane j when it is 0.
- R5: Column stage: for column y, the output at row i takes the row-stage word at row (i·COL_MUL + COL_OFS + y) mod K when column-word bit y is 1, and row i when it is 0.
- R6: The word of element (x,y) occupies fwd_data_i bits [(x·K+y)·6 +: 6]; the output word at (i,y) occupies fwd_data_o bits [(i·K+y)·6 +: 6], and row i of the output goes to check unit i.
- R7: A forward beat sampled with fwd_vld_i high at edge n appears on fwd_data_o after edge n+1 with fwd_vld_o high; fwd_vld_o is low after edge n+1 when no beat was sampled at edge n.
- R8: A forward sample with fwd_vld_i low is ignored: fwd_data_o keeps its previous value.
- R9: A return beat sampled at edge m is mapped through the inverse of the column stage and then the inverse of the row stage, using the control words of the forward beat sampled at edge m−3; a result returned in that slot reaches the lane of the element that produced it. Return words are 5 bits, with the same position layout as in R6.
- R10: A return beat sampled at edge m appears on bwd_data_o after edge m+1 with bwd_vld_o high; a sample with bwd_vld_i low leaves bwd_data_o unchanged and gives bwd_vld_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Restart the control table index at entry 0 on this edge |
| fwd_vld_i | input | 1 | Forward beat present |
| fwd_data_i | input | K·K·FW | Words from the processing-element array, row-major |
| fwd_vld_o | output | 1 | Forward result valid |
| fwd_data_o | output | K·K·FW | Shuffled words; row i is for check unit i |
| bwd_vld_i | input | 1 | Return beat present |
| bwd_data_i | input | K·K·BW | Results from the check units, row-major |
| bwd_vld_o | output | 1 | Return result valid |
| bwd_data_o | output | K·K·BW | Unshuffled results, one per processing element |

## Verification
The bench drives a stream of beats and keeps track of the table entry on every edge. For each beat it works out the expected permutation directly from the formulas, and it sends each forward output back as a return beat exactly three edges after the forward beat was sampled. Bursts with gaps show whether the index advances on empty cycles. A design that counted only valid beats would pick the wrong words after the first gap. Start pulses, including two in a row, expose an index that fails to restart or that applies the restart one edge late. Every lane of the round trip must come back to its own element. Swapping the inverse for the forward permutation would fail this, and so would using the wrong control delay: both send results to the wrong element. Random data is placed on the inputs during invalid cycles, so an output register that loads without its valid flag shows up at once.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

  typedef enum logic {
    SEL_IDENT = 1'b0,
    SEL_PERM  = 1'b1
  } sel_e;

  // Source lane feeding output lane j of a fixed permutation.
  function automatic int unsigned perm_src(int unsigned k, int unsigned mul,
                                           int unsigned ofs, int unsigned j);
    return (j * mul + ofs) % k;
  endfunction

  // Output lane that carries input lane m (inverse permutation).
  function automatic int unsigned perm_inv(int unsigned k, int unsigned mul,
                                           int unsigned ofs, int unsigned m);
    int unsigned res;
    res = 0;
    for (int unsigned j = 0; j < k; j++) begin
      if (perm_src(k, mul, ofs, j) == m) res = j;
    end
    return res;
  endfunction

  function automatic logic [63:0] rotl(logic [63:0] v, int unsigned k, int unsigned s);
    logic [63:0] r;
    r = '0;
    for (int unsigned b = 0; b < k; b++) begin
      r[b] = v[(b + k - (s % k)) % k];
    end
    return r;
  endfunction

  function automatic logic [63:0] row_word(int unsigned k, logic [63:0] seed, int unsigned e);
    return rotl(seed, k, e % k) ^ 64'(e);
  endfunction

  function automatic logic [63:0] col_word(int unsigned k, logic [63:0] seed, int unsigned e);
    return rotl(seed, k, (e + 1) % k) ^ 64'(3 * e);
  endfunction

endpackage

// File: rtl/lane_shuffler.sv
module lane_shuffler #(
  parameter int unsigned W      = 6,
  parameter int unsigned K      = 4,
  parameter int unsigned MUL    = 1,
  parameter int unsigned OFS    = 0,
  parameter bit          INVERT = 1'b0
) (
  input  logic           sel_i,
  input  logic [K*W-1:0] din_i,
  output logic [K*W-1:0] dout_o
);
  import shuf_pkg::*;

  sel_e mode;
  assign mode = sel_e'(sel_i);

  for (genvar j = 0; j < K; j++) begin : g_lane
    localparam int unsigned SRC = INVERT ? perm_inv(K, MUL, OFS, j)
                                         : perm_src(K, MUL, OFS, j);
    assign dout_o[j*W +: W] = (mode == SEL_PERM) ? din_i[SRC*W +: W]
                                                 : din_i[j*W +: W];
  end

endmodule

// File: rtl/shuf_core.sv
module shuf_core #(
  parameter int unsigned W       = 6,
  parameter int unsigned K       = 4,
  parameter int unsigned ROW_MUL = 3,
  parameter int unsigned ROW_OFS = 1,
  parameter int unsigned COL_MUL = 3,
  parameter int unsigned COL_OFS = 2,
  parameter bit          REV     = 1'b0
) (
  input  logic [K-1:0]     row_sel_i,
  input  logic [K-1:0]     col_sel_i,
  input  logic [K*K*W-1:0] din_i,
  output logic [K*K*W-1:0] dout_o
);
  localparam int unsigned BLK = K * K * W;

  logic [BLK-1:0] row_in, row_out, col_in, col_out;

  // Stage ordering: forward runs rows then columns; reverse undoes columns first.
  if (REV) begin : g_rev_order
    assign col_in = din_i;
    assign row_in = col_out;
    assign dout_o = row_out;
  end else begin : g_fwd_order
    assign row_in = din_i;
    assign col_in = row_out;
    assign dout_o = col_out;
  end

  for (genvar x = 0; x < K; x++) begin : g_row
    lane_shuffler #(
      .W(W), .K(K), .MUL(ROW_MUL), .OFS(ROW_OFS + x), .INVERT(REV)
    ) i_row (
      .sel_i  (row_sel_i[x]),
      .din_i  (row_in[x*K*W +: K*W]),
      .dout_o (row_out[x*K*W +: K*W])
    );
  end

  for (genvar y = 0; y < K; y++) begin : g_col
    logic [K*W-1:0] gath, scat;
    for (genvar i = 0; i < K; i++) begin : g_pick
      assign gath[i*W +: W]          = col_in[(i*K + y)*W +: W];
      assign col_out[(i*K + y)*W +: W] = scat[i*W +: W];
    end
    lane_shuffler #(
      .W(W), .K(K), .MUL(COL_MUL), .OFS(COL_OFS + y), .INVERT(REV)
    ) i_col (
      .sel_i  (col_sel_i[y]),
      .din_i  (gath),
      .dout_o (scat)
    );
  end

endmodule

// File: rtl/shuf_ctrl.sv
module shuf_ctrl #(
  parameter int unsigned K        = 4,
  parameter int unsigned L        = 8,
  parameter int unsigned ROW_SEED = 6,
  parameter int unsigned COL_SEED = 11,
  parameter int unsigned RET_DLY  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  output logic [$clog2(L)-1:0] idx_o,
  output logic [K-1:0]         row_fwd_o,
  output logic [K-1:0]         col_fwd_o,
  output logic [K-1:0]         row_ret_o,
  output logic [K-1:0]         col_ret_o
);
  localparam int unsigned IW = $clog2(L);
  localparam logic [IW-1:0] LAST = IW'(L - 1);

  logic [K-1:0]  row_tbl [L];
  logic [K-1:0]  col_tbl [L];
  logic [IW-1:0] cnt_q;
  logic [IW-1:0] rd_idx;

  for (genvar e = 0; e < L; e++) begin : g_tbl
    localparam logic [63:0] RW = shuf_pkg::row_word(K, 64'(ROW_SEED), e);
    localparam logic [63:0] CW = shuf_pkg::col_word(K, 64'(COL_SEED), e);
    assign row_tbl[e] = RW[K-1:0];
    assign col_tbl[e] = CW[K-1:0];
  end

  assign rd_idx = start_i ? '0 : cnt_q;
  assign idx_o  = rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      row_fwd_o <= '0;
      col_fwd_o <= '0;
    end else begin
      cnt_q     <= (rd_idx == LAST) ? '0 : rd_idx + 1'b1;
      row_fwd_o <= row_tbl[rd_idx];
      col_fwd_o <= col_tbl[rd_idx];
    end
  end

  // Replay line: the return path sees each control word RET_DLY cycles later.
  logic [K-1:0] row_dly [RET_DLY];
  logic [K-1:0] col_dly [RET_DLY];

  for (genvar d = 0; d < RET_DLY; d++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_dly[d] <= '0;
        col_dly[d] <= '0;
      end else if (d == 0) begin
        row_dly[d] <= row_fwd_o;
        col_dly[d] <= col_fwd_o;
      end else begin
        row_dly[d] <= row_dly[(d == 0) ? 0 : d-1];
        col_dly[d] <= col_dly[(d == 0) ? 0 : d-1];
      end
    end
  end

  assign row_ret_o = row_dly[RET_DLY-1];
  assign col_ret_o = col_dly[RET_DLY-1];

endmodule

// File: rtl/shuffle_net.sv
module shuffle_net #(
  parameter int unsigned K_LOG2   = 2,
  parameter int unsigned L        = 8,
  parameter int unsigned FW       = 6,
  parameter int unsigned BW       = 5,
  parameter int unsigned ROW_MUL  = 3,
  parameter int unsigned ROW_OFS  = 1,
  parameter int unsigned COL_MUL  = 3,
  parameter int unsigned COL_OFS  = 2,
  parameter int unsigned ROW_SEED = 6,
  parameter int unsigned COL_SEED = 11,
  parameter int unsigned RET_DLY  = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start_i,
  input  logic                               fwd_vld_i,
  input  logic [(1<<(2*K_LOG2))*FW-1:0]      fwd_data_i,
  output logic                               fwd_vld_o,
  output logic [(1<<(2*K_LOG2))*FW-1:0]      fwd_data_o,
  input  logic                               bwd_vld_i,
  input  logic [(1<<(2*K_LOG2))*BW-1:0]      bwd_data_i,
  output logic                               bwd_vld_o,
  output logic [(1<<(2*K_LOG2))*BW-1:0]      bwd_data_o
);
  localparam int unsigned K    = 1 << K_LOG2;
  localparam int unsigned IW   = $clog2(L);
  localparam int unsigned FBLK = K * K * FW;
  localparam int unsigned BBLK = K * K * BW;

  logic [K-1:0]  row_fwd, col_fwd, row_ret, col_ret;
  logic [IW-1:0] tbl_idx;

  shuf_ctrl #(
    .K(K), .L(L), .ROW_SEED(ROW_SEED), .COL_SEED(COL_SEED), .RET_DLY(RET_DLY)
  ) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .idx_o     (tbl_idx),
    .row_fwd_o (row_fwd),
    .col_fwd_o (col_fwd),
    .row_ret_o (row_ret),
    .col_ret_o (col_ret)
  );

  // Forward path: input register, two shuffle stages, output register.
  logic [FBLK-1:0] fwd_in_q, fwd_mix;
  logic            fwd_in_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_in_q   <= '0;
      fwd_in_v   <= 1'b0;
      fwd_data_o <= '0;
      fwd_vld_o  <= 1'b0;
    end else begin
      fwd_in_v  <= fwd_vld_i;
      fwd_vld_o <= fwd_in_v;
      if (fwd_vld_i) fwd_in_q   <= fwd_data_i;
      if (fwd_in_v)  fwd_data_o <= fwd_mix;
    end
  end

  shuf_core #(
    .W(FW), .K(K), .ROW_MUL(ROW_MUL), .ROW_OFS(ROW_OFS),
    .COL_MUL(COL_MUL), .COL_OFS(COL_OFS), .REV(1'b0)
  ) i_fwd (
    .row_sel_i (row_fwd),
    .col_sel_i (col_fwd),
    .din_i     (fwd_in_q),
    .dout_o    (fwd_mix)
  );

  // Return path: separate wires, inverse stages, delayed control.
  logic [BBLK-1:0] bwd_in_q, bwd_mix;
  logic            bwd_in_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bwd_in_q   <= '0;
      bwd_in_v   <= 1'b0;
      bwd_data_o <= '0;
      bwd_vld_o  <= 1'b0;
    end else begin
      bwd_in_v  <= bwd_vld_i;
      bwd_vld_o <= bwd_in_v;
      if (bwd_vld_i) bwd_in_q   <= bwd_data_i;
      if (bwd_in_v)  bwd_data_o <= bwd_mix;
    end
  end

  shuf_core #(
    .W(BW), .K(K), .ROW_MUL(ROW_MUL), .ROW_OFS(ROW_OFS),
    .COL_MUL(COL_MUL), .COL_OFS(COL_OFS), .REV(1'b1)
  ) i_bwd (
    .row_sel_i (row_ret),
    .col_sel_i (col_ret),
    .din_i     (bwd_in_q),
    .dout_o    (bwd_mix)
  );

endmodule

// File: rtl/shuffle_net_chk.sv
module shuffle_net_chk #(
  parameter int unsigned K_LOG2 = 2,
  parameter int unsigned L      = 8,
  parameter int unsigned FW     = 6,
  parameter int unsigned BW     = 5
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          start_i,
  input logic                          fwd_vld_i,
  input logic [(1<<(2*K_LOG2))*FW-1:0] fwd_data_i,
  input logic                          fwd_vld_o,
  input logic [(1<<(2*K_LOG2))*FW-1:0] fwd_data_o,
  input logic                          bwd_vld_i,
  input logic [(1<<(2*K_LOG2))*BW-1:0] bwd_data_i,
  input logic                          bwd_vld_o,
  input logic [(1<<(2*K_LOG2))*BW-1:0] bwd_data_o,
  input logic [$clog2(L)-1:0]          tbl_idx,
  input logic [(1<<K_LOG2)-1:0]        row_fwd,
  input logic [(1<<K_LOG2)-1:0]        col_fwd,
  input logic [(1<<K_LOG2)-1:0]        row_ret,
  input logic [(1<<K_LOG2)-1:0]        col_ret
);
  logic [2:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seen <= '0;
    else if (seen != 3'd7) seen <= seen + 1'b1;
  end

  a_r2_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd1 && !start_i) |-> (int'(tbl_idx) == (int'($past(tbl_idx)) + 1) % L));

  a_r7_fwd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd2) |-> (fwd_vld_o == $past(fwd_vld_i, 2)));

  a_r8_fwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd3 && !$past(fwd_vld_i, 2)) |-> $stable(fwd_data_o));

  // R4 and R5: a permutation keeps the count of set bits
  a_r5_fwd_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd2 && fwd_vld_o) |-> ($countones(fwd_data_o) == $countones($past(fwd_data_i, 2))));

  a_r9_ret_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd3) |-> (row_ret == $past(row_fwd, 3) && col_ret == $past(col_fwd, 3)));

  a_r9_bwd_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd2 && bwd_vld_o) |-> ($countones(bwd_data_o) == $countones($past(bwd_data_i, 2))));

  a_r10_bwd_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd2) |-> (bwd_vld_o == $past(bwd_vld_i, 2)));

  a_r10_bwd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seen >= 3'd3 && !$past(bwd_vld_i, 2)) |-> $stable(bwd_data_o));

endmodule

bind shuffle_net shuffle_net_chk #(
  .K_LOG2(K_LOG2), .L(L), .FW(FW), .BW(BW)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .fwd_vld_i  (fwd_vld_i),
  .fwd_data_i (fwd_data_i),
  .fwd_vld_o  (fwd_vld_o),
  .fwd_data_o (fwd_data_o),
  .bwd_vld_i  (bwd_vld_i),
  .bwd_data_i (bwd_data_i),
  .bwd_vld_o  (bwd_vld_o),
  .bwd_data_o (bwd_data_o),
  .tbl_idx    (tbl_idx),
  .row_fwd    (row_fwd),
  .col_fwd    (col_fwd),
  .row_ret    (row_ret),
  .col_ret    (col_ret)
);

// File: tb/test_shuffle_net.sv
module test_shuffle_net;
  localparam int K  = 4;
  localparam int L  = 8;
  localparam int RM = 3, RO = 1, CM = 3, CO = 2;
  localparam int RS = 6, CS = 11;
  localparam int N  = 330;
  localparam int DW = K*K*6;
  localparam int RW = K*K*5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, start_i, fwd_vld_i, fwd_vld_o, bwd_vld_i, bwd_vld_o;
  logic [DW-1:0] fwd_data_i, fwd_data_o;
  logic [RW-1:0] bwd_data_i, bwd_data_o;

  shuffle_net #(
    .K_LOG2(2), .L(L), .FW(6), .BW(5), .ROW_MUL(RM), .ROW_OFS(RO),
    .COL_MUL(CM), .COL_OFS(CO), .ROW_SEED(RS), .COL_SEED(CS), .RET_DLY(3)
  ) i_shuffle_net (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .fwd_vld_i(fwd_vld_i), .fwd_data_i(fwd_data_i),
    .fwd_vld_o(fwd_vld_o), .fwd_data_o(fwd_data_o),
    .bwd_vld_i(bwd_vld_i), .bwd_data_i(bwd_data_i),
    .bwd_vld_o(bwd_vld_o), .bwd_data_o(bwd_data_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  logic [DW-1:0] din_h [N];
  logic [DW-1:0] obs_h [N];
  bit            fv_h [N], bv_h [N], ov_h [N], st_h [N];
  int            e_h  [N];

  task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] rotl(logic [3:0] v, int s);
    logic [3:0] r;
    for (int b = 0; b < 4; b++) r[b] = v[(b + 4 - s) % 4];
    return r;
  endfunction

  function automatic logic [3:0] rword(int e);
    return rotl(4'(RS), e % K) ^ 4'(e);
  endfunction

  function automatic logic [3:0] cword(int e);
    return rotl(4'(CS), (e + 1) % K) ^ 4'(3 * e);
  endfunction

  function automatic logic [DW-1:0] fwd_model(logic [DW-1:0] d, int e);
    logic [5:0] a [K][K];
    logic [5:0] b [K][K];
    logic [DW-1:0] r;
    logic [3:0] rw, cw;
    rw = rword(e);
    cw = cword(e);
    for (int x = 0; x < K; x++)
      for (int y = 0; y < K; y++) a[x][y] = d[(x*K + y)*6 +: 6];
    for (int x = 0; x < K; x++)
      for (int j = 0; j < K; j++)
        b[x][j] = rw[x] ? a[x][(j*RM + RO + x) % K] : a[x][j];
    for (int i = 0; i < K; i++)
      for (int y = 0; y < K; y++)
        r[(i*K + y)*6 +: 6] = cw[y] ? b[(i*CM + CO + y) % K][y] : b[i][y];
    return r;
  endfunction

  function automatic logic [RW-1:0] trunc5(logic [DW-1:0] d);
    logic [RW-1:0] r;
    for (int i = 0; i < K*K; i++) r[i*5 +: 5] = d[i*6 +: 5];
    return r;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired before the run completed");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] exp_f;
    logic [RW-1:0] exp_b;
    int next_e;
    rst_n = 1'b0; start_i = 1'b0; fwd_vld_i = 1'b0; bwd_vld_i = 1'b0;
    fwd_data_i = '0; bwd_data_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(fwd_vld_o == 1'b0, "R1 fwd_vld_o", DW'(fwd_vld_o), '0);
    check(fwd_data_o == '0,  "R1 fwd_data_o", fwd_data_o, '0);
    check(bwd_vld_o == 1'b0, "R1 bwd_vld_o", DW'(bwd_vld_o), '0);
    check(bwd_data_o == '0,  "R1 bwd_data_o", DW'(bwd_data_o), '0);
    rst_n  = 1'b1;
    next_e = 0;
    exp_f  = '0;
    exp_b  = '0;

    for (int m = 0; m < N; m++) begin
      // Forward result for the beat sampled at edge m-2
      if (m >= 2) begin
        if (fv_h[m-2]) begin
          exp_f = fwd_model(din_h[m-2], e_h[m-2]);
          check(fwd_vld_o == 1'b1, "R7 fwd_vld_o", DW'(fwd_vld_o), DW'(1));
          check(fwd_data_o == exp_f,
                st_h[m-2] ? "R2 start restart" : "R2 R3 R4 R5 R6 fwd",
                fwd_data_o, exp_f);
        end else begin
          check(fwd_vld_o == 1'b0, "R7 fwd_vld_o idle", DW'(fwd_vld_o), '0);
          check(fwd_data_o == exp_f, "R8 fwd hold", fwd_data_o, exp_f);
        end
      end else begin
        check(fwd_vld_o == 1'b0, "R1 fwd_vld_o after reset", DW'(fwd_vld_o), '0);
      end
      obs_h[m] = fwd_data_o;
      ov_h[m]  = fwd_vld_o;

      // Return result for the beat sampled at edge m-2 (forward beat m-5)
      if (m >= 2) begin
        if (bv_h[m-2]) begin
          exp_b = trunc5(din_h[m-5]);
          check(bwd_vld_o == 1'b1, "R10 bwd_vld_o", DW'(bwd_vld_o), DW'(1));
          check(bwd_data_o == exp_b, "R9 round trip", DW'(bwd_data_o), DW'(exp_b));
        end else begin
          check(bwd_vld_o == 1'b0, "R10 bwd_vld_o idle", DW'(bwd_vld_o), '0);
          check(bwd_data_o == exp_b, "R10 bwd hold", DW'(bwd_data_o), DW'(exp_b));
        end
      end

      // Drive the forward side for edge m
      st_h[m] = (m == 40 || m == 41 || m == 130 || m == 205 || m == 262);
      if (m < 110)      fv_h[m] = 1'b1;
      else if (m < 220) fv_h[m] = (m % 3) != 0;
      else              fv_h[m] = $urandom_range(0, 1) == 1;
      if (m >= N - 6) fv_h[m] = 1'b0;
      for (int w = 0; w < K*K; w++) begin
        if (m < 110)      din_h[m][w*6 +: 6] = 6'(w) | 6'((m % 4) << 4);
        else if (m < 220) din_h[m][w*6 +: 6] = 6'($urandom);
        else              din_h[m][w*6 +: 6] = (w == m % (K*K)) ? 6'h3F : 6'h00;
      end
      e_h[m]  = st_h[m] ? 0 : next_e;
      next_e  = (e_h[m] + 1) % L;
      start_i   = st_h[m];
      fwd_vld_i = fv_h[m];
      fwd_data_i = fv_h[m] ? din_h[m] : DW'({$urandom, $urandom, $urandom});

      // Return side: send back the forward output of beat m-3
      bv_h[m]   = (m >= 1) ? ov_h[m-1] : 1'b0;
      bwd_vld_i = bv_h[m];
      bwd_data_i = bv_h[m] ? trunc5(obs_h[m-1]) : RW'({$urandom, $urandom, $urandom});

      @(negedge clk);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule